// File: doc/BRIEF.md
# Nibble-Serial SAR ADC Controller

This block turns one conversion request into a 12-bit code by binary search. It drives one channel of an external current-output DAC whose input is a 4-bit bus into three addressed nibble registers. It also reads an external comparator that reports whether the analog input is at or above the DAC output. The search runs one nibble at a time, starting with the most significant. Each trial bit is written into the selected nibble register and then moved into the converting DAC by a low pulse on the update strobe. The comparator is read only after a programmable settling time.

The controller is used as the conversion engine of a slow analog input port. A pulse on start begins a conversion. The finished code is presented in three forms: the full 12-bit word, the top nibble on its own, and the lower two nibbles packed into one byte. A one-cycle done pulse marks the cycle in which all three take their new values.

Top module: `nibble_sar_ctrl`

## Requirements
- R1: After start, and before any update pulse, the controller writes 0 into the nibble registers at addresses 0, 1 and 2, in that order. Each write is a single low pulse on wr_no.
- R2: The search handles address 2 (top nibble), then address 1, then address 0. Each address gets exactly five update pulses.
- R3: A trial at bit b drives data_o with bit b set and the already-decided higher bits of that nibble. It pulls wr_no low, pulses upd_no low for one cycle, and then returns wr_no high. upd_no is never low while wr_no is high.
- R4: The comparator is sampled at the SETTLE_CYC-th rising clock edge after upd_no rises (SETTLE_CYC >= 2). A conversion takes 6 + 3*(4*SETTLE_CYC+13) cycles, counted from the edge that samples start to the edge that raises done_o.
- R5: A comparator value of 1 keeps the trial bit and 0 clears it, so the code is the largest value the DAC can reach without exceeding the input. A fifth write and update per nibble applies the decided value, so the DAC holds the final code when done_o is raised.
- R6: cs_no goes low on the edge that samples start and stays low until done_o. clr_no is always high.
- R7: result_o holds the full code. res_hi_o holds bits 11:8. res_lo_o holds the middle nibble in bits 7:4 and the low nibble in bits 3:0.
- R8: done_o is high for one cycle. result_o, res_hi_o and res_lo_o change only in that cycle.
- R9: start_i is ignored while a conversion is running. It changes neither the result nor the timing, and it causes no second conversion.
- R10: During reset cs_no, wr_no and upd_no are high, done_o is low and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Comparator, 1 when input is at or above DAC output |
| cs_no | output | 1 | DAC chip select, active low |
| clr_no | output | 1 | DAC clear, held inactive high |
| addr_o | output | 2 | Nibble register address |
| data_o | output | 4 | DAC data bus |
| wr_no | output | 1 | Register write strobe, active low |
| upd_no | output | 1 | DAC update strobe, active low |
| done_o | output | 1 | One-cycle conversion-complete pulse |
| result_o | output | 12 | Conversion result |
| res_hi_o | output | 4 | Top nibble of the result |
| res_lo_o | output | 8 | Middle nibble (upper half) and low nibble (lower half) |

## Verification
The bench builds the controller with SETTLE_CYC set to 3. This is one cycle above the minimum, so a sample taken one edge too early is a real timing fault, not a coincidence. The bench comparator gives the inverted answer until that many edges have passed since the update rising edge, so an early sample yields a wrong code. With this value the exact start-to-done latency is a short, checkable number of cycles. The per-trial bus model, which rebuilds the DAC registers from the strobes, can then confirm every one of the fifteen update pulses in each conversion.

// File: rtl/nsar_pkg.sv
package nsar_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ZWR,
    ST_ZREL,
    ST_WRLO,
    ST_UPDLO,
    ST_UPDHI,
    ST_WRHI,
    ST_SETTLE,
    ST_STORE,
    ST_DONE
  } nsar_state_e;
endpackage

// File: rtl/nsar_settle.sv
module nsar_settle #(
  parameter int SETTLE_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (restart_i)        cnt_q <= '0;
    else if (cnt_q != LAST)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LAST);

  initial begin
    assert (SETTLE_CYC >= 2) else $error("SETTLE_CYC must be at least 2");
  end
endmodule

// File: rtl/nsar_nibble.sv
module nsar_nibble #(
  parameter int NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_first_i,
  input  logic             decide_i,
  input  logic             keep_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             last_o
);
  localparam logic [NIB_W-1:0] MSB = {1'b1, {(NIB_W-1){1'b0}}};

  logic [NIB_W-1:0] nib_q, trial_q, kept;

  assign kept = keep_i ? nib_q : (nib_q & ~trial_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nib_q   <= '0;
      trial_q <= '0;
    end else if (clear_i) begin
      nib_q   <= '0;
      trial_q <= '0;
    end else if (load_first_i) begin
      nib_q   <= MSB;
      trial_q <= MSB;
    end else if (decide_i) begin
      trial_q <= trial_q >> 1;
      nib_q   <= kept | (trial_q >> 1);
    end
  end

  assign nib_o  = nib_q;
  assign last_o = trial_q[0];

  // R3
  trial_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trial_q));
endmodule

// File: rtl/nsar_result.sv
module nsar_result #(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 3,
  parameter int ADDR_W  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     store_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-1:0]        sel_i,
  input  logic [NIB_W-1:0]         nib_i,
  output logic [NIB_W*NUM_NIB-1:0] result_o
);
  localparam int RES_W = NIB_W * NUM_NIB;

  logic [RES_W-1:0] acc_q, acc_d, res_q;

  for (genvar g = 0; g < NUM_NIB; g++) begin : g_slot
    assign acc_d[g*NIB_W +: NIB_W] =
      (store_i && sel_i == ADDR_W'(g)) ? nib_i : acc_q[g*NIB_W +: NIB_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      res_q <= '0;
    end else begin
      acc_q <= acc_d;
      if (commit_i) res_q <= acc_d;
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/nibble_sar_ctrl.sv
module nibble_sar_ctrl
  import nsar_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int NUM_NIB    = 3,
  parameter int ADDR_W     = 2,
  parameter int SETTLE_CYC = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     cmp_i,
  output logic                     cs_no,
  output logic                     clr_no,
  output logic [ADDR_W-1:0]        addr_o,
  output logic [NIB_W-1:0]         data_o,
  output logic                     wr_no,
  output logic                     upd_no,
  output logic                     done_o,
  output logic [NIB_W*NUM_NIB-1:0] result_o,
  output logic [NIB_W-1:0]         res_hi_o,
  output logic [2*NIB_W-1:0]       res_lo_o
);
  localparam int RES_W = NIB_W * NUM_NIB;
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NUM_NIB - 1);

  nsar_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic fin_q, fin_d;
  logic expired, decide, load_first, store, commit, last_bit;
  logic [NIB_W-1:0] nib;

  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    fin_d      = fin_q;
    decide     = 1'b0;
    load_first = 1'b0;
    store      = 1'b0;
    commit     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_ZWR;
        addr_d  = '0;
      end
      ST_ZWR:  state_d = ST_ZREL;
      ST_ZREL: begin
        if (addr_q == TOP_ADDR) begin
          state_d    = ST_WRLO;
          load_first = 1'b1;
          fin_d      = 1'b0;
        end else begin
          state_d = ST_ZWR;
          addr_d  = addr_q + 1'b1;
        end
      end
      ST_WRLO:  state_d = ST_UPDLO;
      ST_UPDLO: state_d = ST_UPDHI;
      ST_UPDHI: state_d = ST_WRHI;
      ST_WRHI, ST_SETTLE: begin
        if (state_q == ST_WRHI && fin_q) begin
          state_d = ST_STORE;
        end else if (expired) begin
          decide  = 1'b1;
          fin_d   = last_bit;
          state_d = ST_WRLO;
        end else begin
          state_d = ST_SETTLE;
        end
      end
      ST_STORE: begin
        store = 1'b1;
        if (addr_q == '0) begin
          commit  = 1'b1;
          state_d = ST_DONE;
        end else begin
          addr_d     = addr_q - 1'b1;
          load_first = 1'b1;
          fin_d      = 1'b0;
          state_d    = ST_WRLO;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      fin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      fin_q   <= fin_d;
    end
  end

  nsar_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i, .rst_ni,
    .restart_i (state_q == ST_UPDLO),
    .expired_o (expired)
  );

  nsar_nibble #(.NIB_W(NIB_W)) u_nibble (
    .clk_i, .rst_ni,
    .clear_i      (state_q == ST_IDLE),
    .load_first_i (load_first),
    .decide_i     (decide),
    .keep_i       (cmp_i),
    .nib_o        (nib),
    .last_o       (last_bit)
  );

  nsar_result #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB), .ADDR_W(ADDR_W)) u_result (
    .clk_i, .rst_ni,
    .store_i  (store),
    .commit_i (commit),
    .sel_i    (addr_q),
    .nib_i    (nib),
    .result_o (result_o)
  );

  assign cs_no  = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign clr_no = 1'b1;
  assign addr_o = addr_q;
  assign data_o = nib;
  assign wr_no  = !((state_q == ST_ZWR) || (state_q == ST_WRLO) ||
                    (state_q == ST_UPDLO) || (state_q == ST_UPDHI));
  assign upd_no = (state_q != ST_UPDLO);
  assign done_o = (state_q == ST_DONE);
  assign res_hi_o = result_o[RES_W-1 -: NIB_W];
  assign res_lo_o = result_o[2*NIB_W-1:0];

  // R1
  zero_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ZWR) |-> (data_o == '0 && upd_no));
  // R2
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o <= TOP_ADDR);
  // R3
  upd_in_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_no |-> !wr_no);
  // R3
  upd_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_no |=> (upd_no && !wr_no));
  // R6
  cs_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> !cs_no);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
  // R9
  start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(start_i));
endmodule

// File: tb/sim_nibble_sar_ctrl.sv
module sim_nibble_sar_ctrl;
  localparam int SETTLE  = 3;
  localparam int EXP_LAT = 7 + 3 * (4 * SETTLE + 13);
  localparam int NVEC    = 10;
  // {analog input code, expected result}
  localparam logic [23:0] VEC [NVEC] = '{
    {12'h000, 12'h000}, {12'hFFF, 12'hFFF}, {12'h800, 12'h800},
    {12'h7FF, 12'h7FF}, {12'h001, 12'h001}, {12'hA5C, 12'hA5C},
    {12'h3C3, 12'h3C3}, {12'h555, 12'h555}, {12'hAAA, 12'hAAA},
    {12'h123, 12'h123}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmp = 1'b0;
  logic cs_n, clr_n, wr_n, upd_n, done;
  logic [1:0] addr;
  logic [3:0] data, res_hi;
  logic [7:0] res_lo;
  logic [11:0] result;

  int errs = 0, checks = 0, cyc = 0;
  logic [11:0] vin = '0;
  logic [3:0] regs [3];
  logic [11:0] dac = '0;
  int age = 0, wev = 0, uidx = 0;
  int r1_bad = 0, r2_bad = 0, r3_bad = 0, r6_bad = 0, hold_bad = 0;
  logic prev_wr = 1'b1, prev_upd = 1'b1;
  logic [11:0] prev_res = '0;
  logic busy = 1'b0;

  always #4 clk = ~clk;

  nibble_sar_ctrl #(.SETTLE_CYC(SETTLE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
    .cs_no(cs_n), .clr_no(clr_n), .addr_o(addr), .data_o(data),
    .wr_no(wr_n), .upd_no(upd_n), .done_o(done), .result_o(result),
    .res_hi_o(res_hi), .res_lo_o(res_lo)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] trial_exp(logic [11:0] v, int u);
    int n = u / 5;
    int k = u % 5;
    logic [3:0] vn = v[(2-n)*4 +: 4];
    logic [3:0] m;
    if (k == 4) return vn;
    m = 4'hF << (4 - k);
    return (vn & m) | (4'b1 << (3 - k));
  endfunction

  // DAC and comparator model, bus order monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && !wr_n && addr < 2'd3) regs[addr] = data;
      if (prev_wr && !wr_n) begin
        if (wev < 3 && (addr != 2'(wev) || data != 4'h0 || uidx != 0)) r1_bad++;
        wev++;
      end
      if (prev_upd && !upd_n) begin
        if (uidx < 15) begin
          if (addr != 2'(2 - uidx / 5)) r2_bad++;
          if (data != trial_exp(vin, uidx)) r3_bad++;
        end else r2_bad++;
        uidx++;
      end
      if (!upd_n) begin
        dac = {regs[2], regs[1], regs[0]};
        age = 0;
      end else if (age < 100) age++;
      if (busy && (cs_n || !clr_n)) r6_bad++;
      if (!done && result != prev_res) hold_bad++;
      prev_res = result;
      prev_wr  = wr_n;
      prev_upd = upd_n;
    end
    cmp = (age >= SETTLE) ? (vin >= dac) : !(vin >= dac);
  end

  task automatic convert(input logic [11:0] v, input logic [11:0] exp, input bit poke);
    int lat;
    vin = v; wev = 0; uidx = 0; r1_bad = 0; r2_bad = 0; r3_bad = 0; r6_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy  = 1'b1;
    lat   = 1;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 30) start = 1'b1;
      else start = 1'b0;
    end
    busy = 1'b0;
    check(result == exp, poke ? "R9 result" : "R5 result", result, exp);
    check(lat == EXP_LAT, poke ? "R9 latency" : "R4 latency", lat, EXP_LAT);
    check(res_hi == exp[11:8] && res_lo == exp[7:0], "R7 split", {res_hi, res_lo}, exp);
    check(dac == exp, "R5 final DAC", dac, exp);
    check(r1_bad == 0, "R1 zero fill", r1_bad, 0);
    check(r2_bad == 0 && uidx == 15, "R2 nibble order", uidx, 15);
    check(r3_bad == 0, "R3 trial data", r3_bad, 0);
    check(r6_bad == 0, "R6 select held", r6_bad, 0);
    @(negedge clk);
    check(!done && cs_n && result == exp, "R8 single pulse", {done, cs_n}, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n && wr_n && upd_n && !done && result == 0 && res_hi == 0 && res_lo == 0,
          "R10 reset", {cs_n, wr_n, upd_n, done}, 4'hE);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) begin
      convert(VEC[i][23:12], VEC[i][11:0], 1'b0);
      repeat (2) @(negedge clk);
    end
    // R9: start during a conversion
    convert(12'h9E1, 12'h9E1, 1'b1);
    begin
      int late = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (!cs_n || done) late++;
      end
      check(late == 0, "R9 no extra conversion", late, 0);
    end
    // R8: held result unchanged across a conversion until its done
    check(hold_bad == 0, "R8 result hold", hold_bad, 0);
    // R6: clear line never asserted
    check(clr_n == 1'b1, "R6 clear inactive", clr_n, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule